// File: doc/BRIEF.md
# Serial ADC Interface Sequencer

This block is the digital control side of an eight-input, 12-bit successive-approximation converter, as seen from a four-wire serial port. The port has a chip select, a serial clock, a data input, a data output and a result strobe. Everything runs on one fast system clock. The three serial inputs are resynchronised, and the rising and falling edges of the serial clock are recovered as single-cycle events.

After chip select goes low, the block waits for the first 1 on the data input. That 1 begins an 8-bit command. The block decodes the channel, the input polarity and the input mode from the command, and drives the track/hold control and the analog multiplexer selects. The conversion runs on the external serial clock and settles one result bit per clock. There is no analog comparator here; a 12-bit input level (`ain_level`) stands in for the voltage being measured. The result leaves MSB first on the data output. A conversion frame lasts 15 serial clocks. If the data input is held high, a new conversion therefore starts every 15 clocks. Power-down requests are only reported on a status flag.

Top module: `adc_serial_seq`

## Requirements
- R1: After reset, `dout`, `res_strobe`, `th_track`, `bipolar` and `pd_flag` are 0, `pos_sel` and `neg_sel` are 0, and `neg_is_gnd` is 1.
- R2: With chip select low, the block samples `din` on each rising serial-clock edge. Leading 0 bits have no effect. The first 1 is the start bit, and the following seven bits are, in order: SEL2, SEL1, SEL0, UNI (1 = unipolar), SGL (1 = single-ended), PD1, PD0.
- R3: `th_track` rises on the falling edge after the fifth command bit. It falls on the falling edge after the eighth bit, which begins hold.
- R4: On the falling edge after the fifth bit, `pos_sel` becomes {SEL1, SEL0, SEL2}.
- R5: On the falling edge after the eighth bit, the negative-input outputs update. In single-ended mode `neg_is_gnd` = 1 and `neg_sel` = 0. In differential mode `neg_is_gnd` = 0 and `neg_sel` = `pos_sel` with its LSB inverted, which is the other member of the pair.
- R6: `res_strobe` is high for exactly one serial-clock period, from the falling edge after the eighth bit to the next falling edge.
- R7: The 12 result bits appear on `dout` MSB first, on the falling edges after serial clocks 9 to 20 of the frame. `dout` is 0 at all other times.
- R8: `bipolar` = not UNI, latched at hold. In unipolar mode the result equals `ain_level`. In bipolar mode `ain_level` is offset binary (2048 = zero), and the result is its two's complement, `ain_level` XOR 0x800.
- R9: Once a start bit has been taken, `din` is ignored through serial clock 15 of the frame, and start-bit search resumes at clock 16. A constant 1 on `din` therefore gives one conversion of command 0xFF (CH7, single-ended, unipolar, no power-down) every 15 clocks.
- R10: While chip select is high, `dout`, `res_strobe` and `th_track` are 0. Any frame in progress is abandoned, and start-bit search begins again when chip select returns low.
- R11: `pd_flag` is set at hold when PD1:PD0 is 00 or 01. It is cleared at hold for 10 or 11, and whenever chip select falls.
- R12: `dout`, `res_strobe` and `th_track` change only on a recovered falling serial-clock edge or while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command input |
| ain_level | input | 12 | Digital stand-in for the sampled input level |
| dout | output | 1 | Serial result output |
| res_strobe | output | 1 | One-clock pulse announcing the result MSB |
| th_track | output | 1 | 1 = track, 0 = hold |
| pos_sel | output | 3 | Positive-input channel select |
| neg_sel | output | 3 | Negative-input channel select (differential) |
| neg_is_gnd | output | 1 | Negative input tied to ground |
| bipolar | output | 1 | Conversion uses two's-complement coding |
| pd_flag | output | 1 | Power-down requested by the last command |

## Verification
The hardest case to reach is the overlap between frames. A new start bit lands on clock 16 while the previous result is still leaving on `dout`, and ones that arrive in clocks 9 to 15 must not start a frame. The bench holds `din` high through several frames and checks every falling edge against a 15-clock cadence worked out arithmetically. It also raises chip select in the middle of tracking and in the middle of the result shift, then checks that the next framed command still converts correctly after a run of leading zeros.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

    localparam int RES_BITS   = 12;
    localparam int CTRL_BITS  = 8;
    localparam int SEL_BITS   = 3;
    localparam int FRAME_LEN  = 15;
    localparam int TRACK_BIT  = 5;
    localparam int SYNC_DEPTH = 2;

    typedef enum logic [0:0] {
        CAP_SEARCH = 1'b0,
        CAP_FRAME  = 1'b1
    } cap_state_e;

    typedef enum logic [1:0] {
        PD_FULL = 2'b00,
        PD_FAST = 2'b01,
        PD_INTC = 2'b10,
        PD_EXTC = 2'b11
    } pd_mode_e;

    // Command payload after the start bit, MSB first as received.
    typedef struct packed {
        logic [SEL_BITS-1:0] sel;
        logic                unipolar;
        logic                single;
        pd_mode_e            pd;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [CTRL_BITS-2:0] raw);
        ctrl_t c;
        c.sel      = raw[6:4];
        c.unipolar = raw[3];
        c.single   = raw[2];
        c.pd       = pd_mode_e'(raw[1:0]);
        return c;
    endfunction

    // Select bits map to a channel as {SEL1, SEL0, SEL2}.
    function automatic logic [SEL_BITS-1:0] pos_channel(input logic [SEL_BITS-1:0] s);
        return {s[1:0], s[2]};
    endfunction

    // The other member of the pair.
    function automatic logic [SEL_BITS-1:0] neg_channel(input logic [SEL_BITS-1:0] s);
        return {s[1:0], ~s[2]};
    endfunction

    function automatic logic requests_pd(input pd_mode_e m);
        return (m == PD_FULL) || (m == PD_FAST);
    endfunction

endpackage

// File: rtl/adcseq_sync.sv
module adcseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n_i,
    input  logic sclk_i,
    input  logic din_i,
    output logic cs_act,
    output logic cs_fall_evt,
    output logic rise_evt,
    output logic fall_evt,
    output logic din_s
);

    localparam logic [2:0] IDLE_VEC = 3'b100;

    logic [STAGES-1:0][2:0] stage_q;
    logic [2:0]             last_q;
    logic                   sclk_d_q;
    logic                   cs_act_d_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= IDLE_VEC;
        end else begin
            stage_q[0] <= {cs_n_i, sclk_i, din_i};
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign last_q = stage_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d_q   <= 1'b0;
            cs_act_d_q <= 1'b0;
        end else begin
            sclk_d_q   <= last_q[1];
            cs_act_d_q <= ~last_q[2];
        end
    end

    assign cs_act      = ~last_q[2];
    assign cs_fall_evt = cs_act & ~cs_act_d_q;
    assign rise_evt    = last_q[1] & ~sclk_d_q;
    assign fall_evt    = ~last_q[1] & sclk_d_q;
    assign din_s       = last_q[0];

endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
    import adcseq_pkg::*;
#(
    parameter int FRAME_CLKS = FRAME_LEN
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_act,
    input  logic                cs_fall_evt,
    input  logic                rise_evt,
    input  logic                fall_evt,
    input  logic                din_s,
    output logic                conv_go,
    output logic                go_bipolar,
    output logic                th_track,
    output logic [SEL_BITS-1:0] pos_sel,
    output logic [SEL_BITS-1:0] neg_sel,
    output logic                neg_is_gnd,
    output logic                bipolar,
    output logic                pd_flag
);

    localparam int CNT_W = $clog2(FRAME_CLKS);
    localparam logic [CNT_W-1:0] CNT_TRACK = CNT_W'(TRACK_BIT);
    localparam logic [CNT_W-1:0] CNT_HOLD  = CNT_W'(CTRL_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(FRAME_CLKS - 1);

    cap_state_e             state_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [CTRL_BITS-2:0]   shreg_q;
    ctrl_t                  cmd;

    assign cmd        = unpack_ctrl(shreg_q);
    assign conv_go    = cs_act && fall_evt && (state_q == CAP_FRAME) && (cnt_q == CNT_HOLD);
    assign go_bipolar = ~cmd.unipolar;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= CAP_SEARCH;
            cnt_q      <= '0;
            shreg_q    <= '0;
            th_track   <= 1'b0;
            pos_sel    <= '0;
            neg_sel    <= '0;
            neg_is_gnd <= 1'b1;
            bipolar    <= 1'b0;
            pd_flag    <= 1'b0;
        end else if (!cs_act) begin
            state_q  <= CAP_SEARCH;
            cnt_q    <= '0;
            th_track <= 1'b0;
        end else begin
            if (cs_fall_evt) pd_flag <= 1'b0;

            if (rise_evt) begin
                if (state_q == CAP_SEARCH) begin
                    if (din_s) begin
                        state_q <= CAP_FRAME;
                        cnt_q   <= CNT_W'(1);
                        shreg_q <= '0;
                    end
                end else begin
                    if (cnt_q < CNT_HOLD) shreg_q <= {shreg_q[CTRL_BITS-3:0], din_s};
                    if (cnt_q == CNT_LAST) begin
                        state_q <= CAP_SEARCH;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end

            if (fall_evt && state_q == CAP_FRAME) begin
                if (cnt_q == CNT_TRACK) begin
                    th_track <= 1'b1;
                    pos_sel  <= pos_channel(shreg_q[3:1]);
                end
                if (cnt_q == CNT_HOLD) begin
                    th_track   <= 1'b0;
                    neg_is_gnd <= cmd.single;
                    neg_sel    <= cmd.single ? '0 : neg_channel(cmd.sel);
                    bipolar    <= ~cmd.unipolar;
                    pd_flag    <= requests_pd(cmd.pd);
                end
            end
        end
    end

endmodule

// File: rtl/adcseq_sar.sv
module adcseq_sar #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_act,
    input  logic             rise_evt,
    input  logic             fall_evt,
    input  logic             conv_go,
    input  logic             go_bipolar,
    input  logic [RES_W-1:0] level,
    output logic             dout,
    output logic             res_strobe
);

    localparam logic [RES_W-1:0] TOP_MASK = {1'b1, {(RES_W-1){1'b0}}};

    logic [RES_W-1:0] sample_q;
    logic [RES_W-1:0] approx_q;
    logic [RES_W-1:0] mask_q;
    logic             run_q;
    logic             pend_q;
    logic             bit_q;
    logic             bip_q;
    logic [RES_W-1:0] trial;
    logic             keep;

    assign trial = approx_q | mask_q;
    assign keep  = (trial <= sample_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_q   <= '0;
            approx_q   <= '0;
            mask_q     <= '0;
            run_q      <= 1'b0;
            pend_q     <= 1'b0;
            bit_q      <= 1'b0;
            bip_q      <= 1'b0;
            dout       <= 1'b0;
            res_strobe <= 1'b0;
        end else if (!cs_act) begin
            run_q      <= 1'b0;
            pend_q     <= 1'b0;
            dout       <= 1'b0;
            res_strobe <= 1'b0;
        end else if (conv_go) begin
            sample_q   <= level;
            approx_q   <= '0;
            mask_q     <= TOP_MASK;
            bip_q      <= go_bipolar;
            run_q      <= 1'b1;
            pend_q     <= 1'b0;
            dout       <= 1'b0;
            res_strobe <= 1'b1;
        end else begin
            if (rise_evt && run_q) begin
                if (keep) approx_q <= trial;
                // Offset binary to two's complement: invert the MSB decision.
                bit_q  <= keep ^ (bip_q & mask_q[RES_W-1]);
                pend_q <= 1'b1;
                mask_q <= mask_q >> 1;
                if (mask_q[0]) run_q <= 1'b0;
            end
            if (fall_evt) begin
                res_strobe <= 1'b0;
                dout       <= pend_q & bit_q;
                pend_q     <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
    import adcseq_pkg::*;
#(
    parameter int RES_W      = RES_BITS,
    parameter int FRAME_CLKS = FRAME_LEN,
    parameter int SYNC_N     = SYNC_DEPTH
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cs_n,
    input  logic                sclk,
    input  logic                din,
    input  logic [RES_W-1:0]    ain_level,
    output logic                dout,
    output logic                res_strobe,
    output logic                th_track,
    output logic [SEL_BITS-1:0] pos_sel,
    output logic [SEL_BITS-1:0] neg_sel,
    output logic                neg_is_gnd,
    output logic                bipolar,
    output logic                pd_flag
);

    logic cs_act;
    logic cs_fall_evt;
    logic rise_evt;
    logic fall_evt;
    logic din_s;
    logic conv_go;
    logic go_bipolar;

    adcseq_sync #(.STAGES(SYNC_N)) u_sync (
        .clk         (clk),
        .rst         (rst),
        .cs_n_i      (cs_n),
        .sclk_i      (sclk),
        .din_i       (din),
        .cs_act      (cs_act),
        .cs_fall_evt (cs_fall_evt),
        .rise_evt    (rise_evt),
        .fall_evt    (fall_evt),
        .din_s       (din_s)
    );

    adcseq_ctrl #(.FRAME_CLKS(FRAME_CLKS)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .cs_act      (cs_act),
        .cs_fall_evt (cs_fall_evt),
        .rise_evt    (rise_evt),
        .fall_evt    (fall_evt),
        .din_s       (din_s),
        .conv_go     (conv_go),
        .go_bipolar  (go_bipolar),
        .th_track    (th_track),
        .pos_sel     (pos_sel),
        .neg_sel     (neg_sel),
        .neg_is_gnd  (neg_is_gnd),
        .bipolar     (bipolar),
        .pd_flag     (pd_flag)
    );

    adcseq_sar #(.RES_W(RES_W)) u_sar (
        .clk        (clk),
        .rst        (rst),
        .cs_act     (cs_act),
        .rise_evt   (rise_evt),
        .fall_evt   (fall_evt),
        .conv_go    (conv_go),
        .go_bipolar (go_bipolar),
        .level      (ain_level),
        .dout       (dout),
        .res_strobe (res_strobe)
    );

endmodule

// File: rtl/adc_serial_seq_chk.sv
module adc_serial_seq_chk (
    input logic clk,
    input logic rst,
    input logic cs_act,
    input logic fall_evt,
    input logic conv_go,
    input logic dout,
    input logic res_strobe,
    input logic th_track
);

    assert_strobe_from_hold_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(res_strobe) |-> $past(conv_go));

    assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
        (res_strobe && fall_evt && !conv_go) |=> !res_strobe);

    assert_dout_on_fall_R12: assert property (@(posedge clk) disable iff (rst)
        !$stable(dout) |-> ($past(fall_evt) || !$past(cs_act)));

    assert_track_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(th_track) |-> ($past(fall_evt) || !$past(cs_act)));

    assert_hold_ends_track_R3: assert property (@(posedge clk) disable iff (rst)
        conv_go |=> !th_track);

    assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> (!dout && !res_strobe && !th_track));

endmodule

bind adc_serial_seq adc_serial_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_act     (cs_act),
    .fall_evt   (fall_evt),
    .conv_go    (conv_go),
    .dout       (dout),
    .res_strobe (res_strobe),
    .th_track   (th_track)
);

// File: tb/sim_adc_serial_seq.sv
module sim_adc_serial_seq;

    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic [11:0] ain_level = '0;
    logic        dout;
    logic        res_strobe;
    logic        th_track;
    logic [2:0]  pos_sel;
    logic [2:0]  neg_sel;
    logic        neg_is_gnd;
    logic        bipolar;
    logic        pd_flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    adc_serial_seq u0 (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .din        (din),
        .ain_level  (ain_level),
        .dout       (dout),
        .res_strobe (res_strobe),
        .th_track   (th_track),
        .pos_sel    (pos_sel),
        .neg_sel    (neg_sel),
        .neg_is_gnd (neg_is_gnd),
        .bipolar    (bipolar),
        .pd_flag    (pd_flag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clk_n(input int n);
        repeat (n) @(posedge clk);
    endtask

    // One serial clock; outputs sampled late in the low phase after the falling edge.
    task automatic sbit(input logic b, output logic d, output logic s, output logic t);
        din = b;
        clk_n(HALF);
        sclk = 1'b1;
        clk_n(HALF);
        sclk = 1'b0;
        clk_n(HALF);
        @(negedge clk);
        d = dout;
        s = res_strobe;
        t = th_track;
    endtask

    task automatic run_frame(input logic [7:0] cb, input logic [11:0] lvl, input int nz);
        logic d, s, t;
        logic [11:0] got;
        logic [11:0] exp_res;
        logic [2:0]  ep;
        got = '0;
        ep  = {cb[5], cb[4], cb[6]};
        ain_level = lvl;
        for (int z = 0; z < nz; z++) begin
            sbit(1'b0, d, s, t);
            chk("R2", "track during leading zeros", t, 0);
        end
        for (int k = 1; k <= 21; k++) begin
            sbit((k <= 8) ? cb[8-k] : 1'b0, d, s, t);
            if (k == 4) chk("R3", "track before fifth bit", t, 0);
            if (k == 5) begin
                chk("R3", "track after fifth bit", t, 1);
                chk("R4", "positive select", pos_sel, ep);
            end
            if (k == 8) begin
                chk("R3", "track after eighth bit", t, 0);
                chk("R6", "strobe at hold", s, 1);
                chk("R5", "negative tied to ground", neg_is_gnd, cb[2]);
                chk("R5", "negative select", neg_sel, cb[2] ? 0 : (ep ^ 3'd1));
                chk("R8", "bipolar flag", bipolar, !cb[3]);
                chk("R11", "power-down flag", pd_flag, !cb[1]);
            end
            if (k == 9) chk("R6", "strobe after one clock", s, 0);
            if (k >= 9 && k <= 20) got[20-k] = d;
            if (k == 21) chk("R7", "dout after LSB", d, 0);
        end
        exp_res = cb[3] ? lvl : (lvl ^ 12'h800);
        chk(cb[3] ? "R7" : "R8", "result word", got, exp_res);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R7 watchdog expired: got busy=1 expected busy=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic d, s, t;
        logic [11:0] lvl;
        clk_n(5);
        rst = 1'b0;
        clk_n(4);
        @(negedge clk);
        chk("R1", "reset dout", dout, 0);
        chk("R1", "reset strobe", res_strobe, 0);
        chk("R1", "reset track", th_track, 0);
        chk("R1", "reset pd flag", pd_flag, 0);
        chk("R1", "reset pos select", pos_sel, 0);
        chk("R1", "reset neg select", neg_sel, 0);
        chk("R1", "reset neg ground", neg_is_gnd, 1);
        chk("R1", "reset bipolar", bipolar, 0);

        // Sweep of every command byte with a chip-select cycle around each frame.
        for (int c = 0; c < 128; c++) begin
            case (c)
                0: lvl = 12'h000;
                1: lvl = 12'hFFF;
                2: lvl = 12'h800;
                3: lvl = 12'h7FF;
                default: lvl = 12'((c * 1237 + 91) % 4096);
            endcase
            cs_n = 1'b0;
            clk_n(4);
            @(negedge clk);
            chk("R11", "pd flag cleared by access", pd_flag, 0);
            run_frame(8'h80 | 8'(c), lvl, c % 4);
            cs_n = 1'b1;
            clk_n(4 * HALF);
        end

        // R9: din held high gives back-to-back 0xFF frames every 15 clocks.
        ain_level = 12'h5A3;
        cs_n = 1'b0;
        clk_n(4);
        for (int k = 1; k <= 60; k++) begin
            int m;
            int p;
            sbit(1'b1, d, s, t);
            m = k % 15;
            chk("R9", "stream strobe", s, (m == 8) ? 1 : 0);
            chk("R9", "stream track", t, (m >= 5 && m <= 7) ? 1 : 0);
            if (k >= 9) begin
                p = (k - 9) % 15;
                chk("R9", "stream dout", d, (p < 12) ? int'(ain_level[11-p]) : 0);
            end else begin
                chk("R9", "stream dout idle", d, 0);
            end
            if (m == 8) chk("R9", "stream select CH7", pos_sel, 7);
        end
        cs_n = 1'b1;
        clk_n(4 * HALF);

        // R10: abort in the middle of the result shift.
        ain_level = 12'hFFF;
        cs_n = 1'b0;
        clk_n(4);
        for (int k = 1; k <= 12; k++) sbit((k <= 8) ? 8'h8F >> (8 - k) : 1'b0, d, s, t);
        chk("R10", "dout high mid result", d, 1);
        cs_n = 1'b1;
        clk_n(4 * HALF);
        @(negedge clk);
        chk("R10", "dout after abort", dout, 0);
        chk("R10", "strobe after abort", res_strobe, 0);

        // R10: abort while tracking.
        cs_n = 1'b0;
        clk_n(4);
        for (int k = 1; k <= 6; k++) sbit(8'h8F >> (8 - k), d, s, t);
        chk("R10", "tracking before abort", t, 1);
        cs_n = 1'b1;
        clk_n(4 * HALF);
        @(negedge clk);
        chk("R10", "track after abort", th_track, 0);

        // Search restarts cleanly: differential bipolar CH1/CH0 after leading zeros.
        cs_n = 1'b0;
        clk_n(4);
        run_frame(8'hC3, 12'h321, 2);
        run_frame(8'hA4, 12'h9C7, 3);
        cs_n = 1'b1;
        clk_n(4 * HALF);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule